// File: doc/BRIEF.md
# Packed ChaCha Quarter-Round Execution Unit

This block is a purely combinational 64-bit functional unit placed beside a RISC-V integer datapath. It runs custom instructions that evaluate parts of the ChaCha add-xor-rotate quarter round on 32-bit words held two to a register. Each instruction takes two packed source operands and a decoded operation select. It returns one packed 64-bit result in the same cycle, with a fixed logic path whatever the data values.

The unit has two operation families. In the fast family, two instructions finish a whole quarter round: the first yields the new a and d words, and the second yields the new b and c words. The second instruction takes the first one's packed result as its first operand. It recovers the intermediate d value from that packed pair, so the unit keeps no hidden state between instructions. In the compact family, four instructions each perform one add-xor-rotate step. All four share a single adder, a single XOR and a single barrel rotator, and the rotation amount comes from the select.

Either family can be left out at elaboration time. The rotation amounts and the word width are parameters, checked when the block is elaborated.

Top module: `qr_packed_unit`

## Requirements
- R1: Source 1 carries word a in bits 63:32 and word d in bits 31:0. Source 2 carries word b in bits 63:32 and word c in bits 31:0. The result holds its first-named output in bits 63:32 and its second in bits 31:0.
- R2: Select 3'd0 (fast A/D) returns {a', d'}, the final a and d of a full quarter round over a, b, c, d.
- R3: Select 3'd1 (fast B/C) receives the fast A/D result as source 1 and the original {b, c} as source 2. It returns {b', c'}, the final b and c of the same quarter round.
- R4: Select 3'd2 returns {a+b, ((a+b) xor d) rotated left by 16}. Select 3'd4 returns the same with a rotation of 8.
- R5: Select 3'd3 returns {((c+d) xor b) rotated left by 12, c+d}. Select 3'd5 returns the same with a rotation of 7.
- R6: Every addition is modulo 2^32 within one 32-bit lane. No carry crosses from one half of the result to the other.
- R7: Selects 3'd6 and 3'd7 return all zeros, whatever the operands.
- R8: The chain 3'd2(X,Y) -> X1, then 3'd3(X1,Y) -> Y1, then 3'd4(X1,Y1) -> R0, then 3'd5(R0,Y1) -> R1 gives R0 = {a', d'} and R1 = {b', c'}.
- R9: The result depends only on the current operands and select, in the same cycle. Earlier operations leave no trace on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src1_i | input | 64 | First packed source operand {a, d} |
| src2_i | input | 64 | Second packed source operand {b, c} |
| op_i | input | 3 | Decoded operation select |
| result_o | output | 64 | Packed result |

## Verification
In the compact family, a step on the a/d pair and a step on the b/c pair use the same adder and rotator, and only the select steers them. The bench drives the same operands in consecutive cycles while the select switches between those steps and between the two rotation amounts. Each cycle's result must match the step selected in that cycle alone. In a second test, a single operation is repeated after an unrelated one, and its result must be unchanged.

// File: rtl/qr_pkg.sv
package qr_pkg;
   localparam int QR_OP_W = 3;

   typedef enum logic [QR_OP_W-1:0] {
      QOP_FAST_AD = 3'd0,
      QOP_FAST_BC = 3'd1,
      QOP_STEP_AD_HI = 3'd2,
      QOP_STEP_BC_HI = 3'd3,
      QOP_STEP_AD_LO = 3'd4,
      QOP_STEP_BC_LO = 3'd5
   } qr_op_e;
endpackage

// File: rtl/qr_fast_path.sv
module qr_fast_path #(
   parameter int WORD_W = 32,
   parameter int ROT_1  = 16,
   parameter int ROT_2  = 12,
   parameter int ROT_3  = 8,
   parameter int ROT_4  = 7,
   localparam int PAIR_W = 2 * WORD_W
) (
   input  logic [PAIR_W-1:0] src1_i,
   input  logic [PAIR_W-1:0] src2_i,
   output logic [PAIR_W-1:0] ad_o,
   output logic [PAIR_W-1:0] bc_o
);
   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t rol(input word_t x, input int unsigned n);
      logic [PAIR_W-1:0] dbl;
      dbl = {x, x} << n;
      return dbl[PAIR_W-1:WORD_W];
   endfunction

   word_t hi1, lo1, hi2, lo2;
   assign hi1 = src1_i[PAIR_W-1:WORD_W];
   assign lo1 = src1_i[WORD_W-1:0];
   assign hi2 = src2_i[PAIR_W-1:WORD_W];
   assign lo2 = src2_i[WORD_W-1:0];

   // first-stage datapath: whole a/d column of a quarter round
   word_t a1, d1, c1, b1, a2, d2;
   always_comb begin
      a1 = hi1 + hi2;
      d1 = rol(a1 ^ lo1, ROT_1);
      c1 = lo2 + d1;
      b1 = rol(c1 ^ hi2, ROT_2);
      a2 = a1 + b1;
      d2 = rol(d1 ^ a2, ROT_3);
   end
   assign ad_o = {a2, d2};

   // second-stage datapath: source 1 is {a', d'}, the mid d is unrotated back
   word_t dm, cm, bm, cf, bf;
   always_comb begin
      dm = hi1 ^ rol(lo1, WORD_W - ROT_3);
      cm = lo2 + dm;
      bm = rol(hi2 ^ cm, ROT_2);
      cf = cm + lo1;
      bf = rol(bm ^ cf, ROT_4);
   end
   assign bc_o = {bf, cf};
endmodule

// File: rtl/qr_step_path.sv
module qr_step_path
   import qr_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int ROT_1  = 16,
   parameter int ROT_2  = 12,
   parameter int ROT_3  = 8,
   parameter int ROT_4  = 7,
   localparam int PAIR_W = 2 * WORD_W,
   localparam int SH_W   = $clog2(WORD_W)
) (
   input  logic [PAIR_W-1:0]  src1_i,
   input  logic [PAIR_W-1:0]  src2_i,
   input  logic [QR_OP_W-1:0] op_i,
   output logic [PAIR_W-1:0]  step_o
);
   typedef logic [WORD_W-1:0] word_t;

   logic          on_bc;
   logic [SH_W-1:0] amt;
   word_t add_l, add_r, mix, sum, xr, rot;
   logic [PAIR_W-1:0] dbl;

   always_comb begin
      on_bc = (op_i == QOP_STEP_BC_HI) || (op_i == QOP_STEP_BC_LO);
      unique case (op_i)
         QOP_STEP_AD_HI: amt = SH_W'(ROT_1);
         QOP_STEP_BC_HI: amt = SH_W'(ROT_2);
         QOP_STEP_AD_LO: amt = SH_W'(ROT_3);
         default:        amt = SH_W'(ROT_4);
      endcase
   end

   // operand steering onto the single shared adder / xor / rotator
   always_comb begin
      add_l = on_bc ? src2_i[WORD_W-1:0] : src1_i[PAIR_W-1:WORD_W];
      add_r = on_bc ? src1_i[WORD_W-1:0] : src2_i[PAIR_W-1:WORD_W];
      mix   = on_bc ? src2_i[PAIR_W-1:WORD_W] : src1_i[WORD_W-1:0];
      sum   = add_l + add_r;
      xr    = sum ^ mix;
      dbl   = {xr, xr} << amt;
      rot   = dbl[PAIR_W-1:WORD_W];
      step_o = on_bc ? {rot, sum} : {sum, rot};
   end
endmodule

// File: rtl/qr_packed_unit.sv
module qr_packed_unit
   import qr_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int ROT_1       = 16,
   parameter int ROT_2       = 12,
   parameter int ROT_3       = 8,
   parameter int ROT_4       = 7,
   parameter bit ENABLE_FAST = 1'b1,
   parameter bit ENABLE_STEP = 1'b1,
   localparam int PAIR_W = 2 * WORD_W
) (
   input  logic [PAIR_W-1:0]  src1_i,
   input  logic [PAIR_W-1:0]  src2_i,
   input  logic [QR_OP_W-1:0] op_i,
   output logic [PAIR_W-1:0]  result_o
);
   initial begin
      if (WORD_W < 8) $error("WORD_W too small");
      if (ROT_1 < 1 || ROT_1 >= WORD_W) $error("ROT_1 out of range");
      if (ROT_2 < 1 || ROT_2 >= WORD_W) $error("ROT_2 out of range");
      if (ROT_3 < 1 || ROT_3 >= WORD_W) $error("ROT_3 out of range");
      if (ROT_4 < 1 || ROT_4 >= WORD_W) $error("ROT_4 out of range");
   end

   logic [PAIR_W-1:0] fast_ad, fast_bc, step_res;

   generate
      if (ENABLE_FAST) begin : g_fast
         qr_fast_path #(.WORD_W(WORD_W), .ROT_1(ROT_1), .ROT_2(ROT_2),
                        .ROT_3(ROT_3), .ROT_4(ROT_4)) u_fast (
            .src1_i(src1_i), .src2_i(src2_i), .ad_o(fast_ad), .bc_o(fast_bc));
      end else begin : g_no_fast
         assign fast_ad = '0;
         assign fast_bc = '0;
      end

      if (ENABLE_STEP) begin : g_step
         qr_step_path #(.WORD_W(WORD_W), .ROT_1(ROT_1), .ROT_2(ROT_2),
                        .ROT_3(ROT_3), .ROT_4(ROT_4)) u_step (
            .src1_i(src1_i), .src2_i(src2_i), .op_i(op_i), .step_o(step_res));
      end else begin : g_no_step
         assign step_res = '0;
      end
   endgenerate

   always_comb begin
      case (op_i)
         QOP_FAST_AD:    result_o = fast_ad;
         QOP_FAST_BC:    result_o = fast_bc;
         QOP_STEP_AD_HI,
         QOP_STEP_BC_HI,
         QOP_STEP_AD_LO,
         QOP_STEP_BC_LO: result_o = step_res;
         default:        result_o = '0;
      endcase
   end
endmodule

// File: rtl/qr_packed_unit_chk.sv
module qr_packed_unit_chk #(
   parameter int WORD_W      = 32,
   parameter int ROT_1       = 16,
   parameter int ROT_2       = 12,
   parameter int ROT_3       = 8,
   parameter int ROT_4       = 7,
   parameter bit ENABLE_FAST = 1'b1,
   parameter bit ENABLE_STEP = 1'b1,
   localparam int PAIR_W = 2 * WORD_W
) (
   input logic [PAIR_W-1:0] src1_i,
   input logic [PAIR_W-1:0] src2_i,
   input logic [2:0]        op_i,
   input logic [PAIR_W-1:0] result_o
);
   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t ror(input word_t x, input int unsigned n);
      logic [PAIR_W-1:0] dbl;
      dbl = {x, x} >> n;
      return dbl[WORD_W-1:0];
   endfunction

   word_t s1h, s1l, s2h, s2l, rh, rl;
   assign s1h = src1_i[PAIR_W-1:WORD_W];
   assign s1l = src1_i[WORD_W-1:0];
   assign s2h = src2_i[PAIR_W-1:WORD_W];
   assign s2l = src2_i[WORD_W-1:0];
   assign rh  = result_o[PAIR_W-1:WORD_W];
   assign rl  = result_o[WORD_W-1:0];

   always_comb begin
      // R9
      result_known_chk: assert (!$isunknown(result_o));
      // R7
      if (op_i > 3'd5) begin
         unused_sel_zero_chk: assert (result_o == '0);
      end
      if (ENABLE_STEP) begin
         // R4
         if (op_i == 3'd2) begin
            step_ad_hi_sum_chk: assert (word_t'(rh - s2h) == s1h);
            step_ad_hi_inv_chk: assert ((ror(rl, ROT_1) ^ rh) == s1l);
         end
         // R4
         if (op_i == 3'd4) begin
            step_ad_lo_sum_chk: assert (word_t'(rh - s2h) == s1h);
            step_ad_lo_inv_chk: assert ((ror(rl, ROT_3) ^ rh) == s1l);
         end
         // R5
         if (op_i == 3'd3) begin
            step_bc_hi_sum_chk: assert (word_t'(rl - s1l) == s2l);
            step_bc_hi_inv_chk: assert ((ror(rh, ROT_2) ^ rl) == s2h);
         end
         // R5
         if (op_i == 3'd5) begin
            step_bc_lo_sum_chk: assert (word_t'(rl - s1l) == s2l);
            step_bc_lo_inv_chk: assert ((ror(rh, ROT_4) ^ rl) == s2h);
         end
      end
      if (ENABLE_FAST) begin
         // R3
         if (op_i == 3'd1) begin
            fast_bc_mid_chk: assert (word_t'(rl - s1l - s2l) == (s1h ^ ror(s1l, ROT_3)));
         end
      end
   end
endmodule

bind qr_packed_unit qr_packed_unit_chk #(
   .WORD_W(WORD_W), .ROT_1(ROT_1), .ROT_2(ROT_2), .ROT_3(ROT_3), .ROT_4(ROT_4),
   .ENABLE_FAST(ENABLE_FAST), .ENABLE_STEP(ENABLE_STEP)
) u_chk (
   .src1_i(src1_i), .src2_i(src2_i), .op_i(op_i), .result_o(result_o)
);

// File: tb/tb_qr_packed_unit.sv
module tb_qr_packed_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] s1 = '0, s2 = '0, res;
   logic [2:0]  op = 3'd7;
   int n_tests = 0;
   int n_fail  = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   qr_packed_unit dut (.src1_i(s1), .src2_i(s2), .op_i(op), .result_o(res));

   function automatic logic [31:0] rol(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function automatic logic [127:0] qr_ref(input logic [31:0] a, b, c, d);
      a = a + b; d = rol(d ^ a, 16);
      c = c + d; b = rol(b ^ c, 12);
      a = a + b; d = rol(d ^ a, 8);
      c = c + d; b = rol(b ^ c, 7);
      return {a, b, c, d};
   endfunction

   function automatic logic [63:0] exp_ad_step(input logic [63:0] x, y, input int r);
      logic [31:0] t;
      t = x[63:32] + y[63:32];
      return {t, rol(t ^ x[31:0], r)};
   endfunction

   function automatic logic [63:0] exp_bc_step(input logic [63:0] x, y, input int r);
      logic [31:0] t;
      t = y[31:0] + x[31:0];
      return {rol(t ^ y[63:32], r), t};
   endfunction

   task automatic apply(input logic [2:0] o, input logic [63:0] a, b);
      @(posedge clk);
      op = o; s1 = a; s2 = b;
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [63:0] expv);
      n_tests++;
      if (res !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, res, expv);
      end
   endtask

   task automatic run_chains(input logic [31:0] a, b, c, d, input string tag);
      logic [127:0] q;
      logic [63:0] x, y, x1, y1, r0;
      q = qr_ref(a, b, c, d);
      x = {a, d}; y = {b, c};
      apply(3'd0, x, y);  check({"R2 fast ad ", tag}, {q[127:96], q[31:0]});
      r0 = res;
      apply(3'd1, r0, y); check({"R3 fast bc ", tag}, {q[95:64], q[63:32]});
      apply(3'd2, x, y);  check({"R4 step ad rot16 ", tag}, exp_ad_step(x, y, 16));
      x1 = res;
      apply(3'd3, x1, y); check({"R5 step bc rot12 ", tag}, exp_bc_step(x1, y, 12));
      y1 = res;
      apply(3'd4, x1, y1); check({"R8 chain a/d ", tag}, {q[127:96], q[31:0]});
      r0 = res;
      apply(3'd5, r0, y1); check({"R8 chain b/c ", tag}, {q[95:64], q[63:32]});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 reset-state unused select", 64'h0);
      rst = 1'b0;

      // published quarter-round vector
      apply(3'd0, {32'h11111111, 32'h01234567}, {32'h01020304, 32'h9b8d6f43});
      check("R2 vector a/d", {32'hea2a92f4, 32'h5881c4bb});
      apply(3'd1, res, {32'h01020304, 32'h9b8d6f43});
      check("R3 vector b/c", {32'hcb1cf8ce, 32'h4581472e});
      run_chains(32'h11111111, 32'h01020304, 32'h9b8d6f43, 32'h01234567, "vector");

      // R1 packing: zero b and d expose a in both halves
      apply(3'd2, {32'h89abcdef, 32'h0}, 64'h0);
      check("R1 packing", {32'h89abcdef, 32'hcdef89ab});

      // R6 lane wrap with no carry into the other half
      apply(3'd2, {32'hffffffff, 32'h0}, {32'h00000001, 32'h0});
      check("R6 ad wrap", 64'h0);
      apply(3'd3, {32'h0, 32'h00000002}, {32'h0, 32'hffffffff});
      check("R6 bc wrap", {32'h00001000, 32'h00000001});

      // R7 unsupported selects
      apply(3'd6, 64'hdeadbeef_cafef00d, 64'h12345678_9abcdef0);
      check("R7 select 6", 64'h0);
      apply(3'd7, 64'hffffffff_ffffffff, 64'h01010101_10101010);
      check("R7 select 7", 64'h0);

      // R9 shared-path alternation and history independence
      for (int i = 0; i < 6; i++) begin
         logic [63:0] p, q;
         logic [63:0] first;
         p = {$urandom, $urandom}; q = {$urandom, $urandom};
         apply(3'd2, p, q); check("R9 alt rot16", exp_ad_step(p, q, 16));
         first = res;
         apply(3'd3, p, q); check("R9 alt rot12", exp_bc_step(p, q, 12));
         apply(3'd4, p, q); check("R4 alt rot8", exp_ad_step(p, q, 8));
         apply(3'd5, p, q); check("R5 alt rot7", exp_bc_step(p, q, 7));
         apply(3'd0, q, p);
         apply(3'd2, p, q); check("R9 repeat", first);
      end

      for (int i = 0; i < 40; i++) begin
         run_chains($urandom, $urandom, $urandom, $urandom, "random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule